// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block sends one SD card command over an SPI-mode link and brings back the card's one-byte R1 reply. The host supplies an 8-bit command field and a 32-bit argument with a one-cycle `start` strobe. The engine then builds the 48-bit command frame itself. It sends the command field and the argument most significant bit first, generates the 7-bit CRC bit by bit as the payload goes out, and closes the frame with a stop bit.

After the frame the engine keeps clocking with the data-out line held high. It watches the card's data line for the leading zero of the reply, then collects eight bits. If no reply starts within a fixed window, the engine reports a timeout and returns an all-ones code. Chip select stays low through one further byte of idle clocks and is then released. A one-cycle `done` strobe marks the end of the transaction.

The serial clock comes from the system clock through a divider that the host can program per command. This lets a slow identification rate and a fast working rate share the same logic. The card's data is sampled on the rising serial clock edge, or, when the host selects it, on the falling edge that closes the bit. The late edge gives a slow card output more time at high clock rates. No synchroniser is used on the card input because the engine owns the clock.

Top module: `sd_spi_cmd_engine`

## Requirements
- R1: A frame is 48 bits sent most significant bit first on `mosi`: the 8 `cmd` bits exactly as given, the 32 `arg` bits, the 7 CRC bits, then a stop bit of 1. `mosi` changes only while `sclk` is low and is stable at each rising edge.
- R2: The CRC uses the polynomial x^7 + x^3 + 1, starts from zero and covers the 40 command and argument bits. For example, command 0x40 with argument 0 ends its frame with the byte 0x95, and command 0x48 with argument 0x000001AA ends with 0x87.
- R3: The host is expected to form `cmd` with bit 7 = 0 (start bit), bit 6 = 1 (transmission bit) and bits 5:0 = command index. The engine sends all 8 bits unchanged and does not check them.
- R4: After the stop bit `mosi` stays 1. The reply begins at the first sampled 0. That bit and the next seven sampled bits, first bit as the most significant bit, are returned on `resp` with `timeout` = 0.
- R5: The reply must start within 64 bit times (8 bytes) after the stop bit. A start in the 64th bit time is still accepted. If none is seen, `timeout` = 1 and `resp` = 0xFF.
- R6: `sclk` rests low when the engine is idle. While a transaction runs, each half period of `sclk` lasts `clk_div` + 1 system clock cycles, using the `clk_div` value captured at `start`.
- R7: With `late_sample` = 0 (captured at `start`), the card input is sampled at the rising `sclk` edge of each bit. With `late_sample` = 1 it is sampled at the falling edge that ends the bit. The late edge reads a card whose output settles more than half a period after the falling edge correctly.
- R8: `cs_n` goes low when a command is accepted. It stays low through the frame, the reply search and eight more `sclk` cycles with `mosi` high, and is then released. The number of rising `sclk` edges with `cs_n` low is 48 + (bit times searched) + 8.
- R9: `busy` is high from the cycle after an accepted `start` until the transaction ends. A `start` seen while `busy` is high is ignored: it changes neither the frame being sent nor what follows.
- R10: `done` is a single-cycle pulse in the cycle where `cs_n` returns high and `busy` falls. `resp` and `timeout` are valid then and hold until the next transaction ends.
- R11: During and after reset `cs_n` = 1, `sclk` = 0, `mosi` = 1, `busy` = 0, `done` = 0, `resp` = 0xFF and `timeout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, taken only when not busy |
| cmd | input | 8 | Command field: start bit, transmission bit, 6-bit index |
| arg | input | 32 | Command argument |
| clk_div | input | DIV_W (8) | Serial clock half period minus one, in system cycles |
| late_sample | input | 1 | 1 = sample card data on the falling edge that ends a bit |
| miso | input | 1 | Serial data from the card |
| sclk | output | 1 | Serial clock to the card |
| cs_n | output | 1 | Active-low card select |
| mosi | output | 1 | Serial data to the card |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| resp | output | 8 | Reply byte, 0xFF on timeout |
| timeout | output | 1 | No reply start seen in the window |

## Verification
Frames are driven with an all-zero argument, a small argument and a dense argument. The two well-known checksum bytes separate a correct polynomial, seed and bit order from near misses, and a bench-side CRC covers the dense case. Replies are placed after gaps of 0, 1, 2, 5 and 63 bit times and also left out entirely. This tells an off-by-one in the search window apart from a correct boundary and gives the exact edge count under chip select in each case. A card model whose output settles only after more than half a serial period is read with late sampling, which only the falling-edge capture handles. A second `start` issued mid-frame with a different command shows whether the busy guard holds.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

    localparam int CMD_W     = 8;
    localparam int ARG_W     = 32;
    localparam int CRC_W     = 7;
    localparam int R1_W      = 8;
    localparam int PAYLOAD_W = CMD_W + ARG_W;          // bits covered by the CRC
    localparam int FRAME_W   = PAYLOAD_W + CRC_W + 1;  // plus stop bit

    typedef struct packed {
        logic [CMD_W-1:0] code;
        logic [ARG_W-1:0] arg;
    } sd_req_t;

    typedef struct packed {
        logic [R1_W-1:0] code;
        logic            timed_out;
    } sd_rsp_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FRAME,
        PH_REPLY,
        PH_TAIL
    } phase_e;

    // One serial step of the x^7 + x^3 + 1 checksum.
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                   input logic              b);
        logic             fb;
        logic [CRC_W-1:0] n;
        fb   = c[CRC_W-1] ^ b;
        n    = {c[CRC_W-2:0], fb};
        n[3] = c[2] ^ fb;
        return n;
    endfunction

endpackage

// File: rtl/sdc_sclk_gen.sv
`timescale 1ns/1ps
module sdc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick      = run && (cnt == half_div);
    assign rise_tick = tick && !sclk;
    assign fall_tick = tick && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R6
    sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk);

endmodule

// File: rtl/sdc_crc7.sv
`timescale 1ns/1ps
module sdc_crc7
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic din,
    input  logic shift,
    output logic msb
);

    logic [CRC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= crc7_step(acc, din);
        end else if (shift) begin
            acc <= {acc[CRC_W-2:0], 1'b0};
        end
    end

    assign msb = acc[CRC_W-1];

endmodule

// File: rtl/sdc_r1_hunter.sv
`timescale 1ns/1ps
module sdc_r1_hunter
    import sdcmd_pkg::*;
#(
    parameter int HUNT_BITS = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    arm,
    input  logic    bit_en,
    input  logic    bit_val,
    output logic    complete,
    output sd_rsp_t rsp
);

    localparam int CW = $clog2(HUNT_BITS + 1);
    localparam int GW = $clog2(R1_W);

    logic          found;
    logic [CW-1:0] wait_cnt;
    logic [GW-1:0] got;
    logic [R1_W-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            found    <= 1'b0;
            wait_cnt <= '0;
            got      <= '0;
            shreg    <= '0;
            complete <= 1'b0;
            rsp      <= '{code: '1, timed_out: 1'b0};
        end else begin
            complete <= 1'b0;
            if (arm) begin
                found    <= 1'b0;
                wait_cnt <= '0;
                got      <= '0;
            end else if (bit_en) begin
                if (!found) begin
                    if (!bit_val) begin
                        found <= 1'b1;
                        shreg <= {shreg[R1_W-3:0], 1'b0};
                        got   <= GW'(1);
                    end else if (wait_cnt == CW'(HUNT_BITS - 1)) begin
                        complete <= 1'b1;
                        rsp      <= '{code: '1, timed_out: 1'b1};
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end else begin
                    shreg <= {shreg[R1_W-3:0], bit_val};
                    got   <= got + 1'b1;
                    if (got == GW'(R1_W - 1)) begin
                        complete <= 1'b1;
                        rsp      <= '{code: {shreg, bit_val}, timed_out: 1'b0};
                    end
                end
            end
        end
    end

    // R4
    reply_lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
        complete && !rsp.timed_out |-> rsp.code[R1_W-1] == 1'b0);

    // R5
    hunt_expired_code_chk: assert property (@(posedge clk) disable iff (rst)
        complete && rsp.timed_out |-> rsp.code == '1);

endmodule

// File: rtl/sd_spi_cmd_engine.sv
`timescale 1ns/1ps
module sd_spi_cmd_engine
    import sdcmd_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int HUNT_BYTES = 8,
    parameter int TAIL_BYTES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       cmd,
    input  logic [31:0]      arg,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             late_sample,
    input  logic             miso,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [7:0]       resp,
    output logic             timeout
);

    localparam int HUNT_BITS = HUNT_BYTES * 8;
    localparam int TAIL_BITS = TAIL_BYTES * 8;
    localparam int IW        = $clog2(FRAME_W);
    localparam int TW        = $clog2(TAIL_BITS + 1);

    phase_e               ph;
    logic [PAYLOAD_W-1:0] pay;
    logic [IW-1:0]        bit_idx;
    logic [TW-1:0]        tail_cnt;
    logic [DIV_W-1:0]     div_q;
    logic                 late_q;
    logic                 miso_rise;
    logic                 run;
    logic                 rise_tick;
    logic                 fall_tick;
    logic                 accept;
    logic                 crc_msb;
    logic                 crc_step_en;
    logic                 crc_shift_en;
    logic                 frame_bit;
    logic                 sample_bit;
    logic                 hunt_done;
    sd_rsp_t              hunt_rsp;
    sd_req_t              req;

    assign req    = '{code: cmd, arg: arg};
    assign accept = (ph == PH_IDLE) && start;
    assign run    = (ph != PH_IDLE);
    assign busy   = run;
    assign cs_n   = !run;

    sdc_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .half_div  (div_q),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign crc_step_en  = (ph == PH_FRAME) && fall_tick && (bit_idx < IW'(PAYLOAD_W));
    assign crc_shift_en = (ph == PH_FRAME) && fall_tick && (bit_idx >= IW'(PAYLOAD_W))
                          && (bit_idx < IW'(FRAME_W - 1));

    sdc_crc7 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (crc_step_en),
        .din   (pay[PAYLOAD_W-1]),
        .shift (crc_shift_en),
        .msb   (crc_msb)
    );

    // Rising-edge capture of the card line; the late path reads it live.
    always_ff @(posedge clk) begin
        if (rst) begin
            miso_rise <= 1'b1;
        end else if (rise_tick) begin
            miso_rise <= miso;
        end
    end

    assign sample_bit = late_q ? miso : miso_rise;

    sdc_r1_hunter #(.HUNT_BITS(HUNT_BITS)) u_hunt (
        .clk      (clk),
        .rst      (rst),
        .arm      (accept),
        .bit_en   ((ph == PH_REPLY) && fall_tick),
        .bit_val  (sample_bit),
        .complete (hunt_done),
        .rsp      (hunt_rsp)
    );

    always_comb begin
        if (bit_idx < IW'(PAYLOAD_W)) begin
            frame_bit = pay[PAYLOAD_W-1];
        end else if (bit_idx < IW'(FRAME_W - 1)) begin
            frame_bit = crc_msb;
        end else begin
            frame_bit = 1'b1;
        end
        mosi = (ph == PH_FRAME) ? frame_bit : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            pay      <= '0;
            bit_idx  <= '0;
            tail_cnt <= '0;
            div_q    <= '0;
            late_q   <= 1'b0;
            done     <= 1'b0;
            resp     <= '1;
            timeout  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        pay     <= req;
                        bit_idx <= '0;
                        div_q   <= clk_div;
                        late_q  <= late_sample;
                        ph      <= PH_FRAME;
                    end
                end
                PH_FRAME: begin
                    if (fall_tick) begin
                        if (bit_idx == IW'(FRAME_W - 1)) begin
                            ph <= PH_REPLY;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx < IW'(PAYLOAD_W)) begin
                                pay <= {pay[PAYLOAD_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                PH_REPLY: begin
                    if (hunt_done) begin
                        tail_cnt <= '0;
                        ph       <= PH_TAIL;
                    end
                end
                PH_TAIL: begin
                    if (fall_tick) begin
                        if (tail_cnt == TW'(TAIL_BITS - 1)) begin
                            ph      <= PH_IDLE;
                            done    <= 1'b1;
                            resp    <= hunt_rsp.code;
                            timeout <= hunt_rsp.timed_out;
                        end else begin
                            tail_cnt <= tail_cnt + 1'b1;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R6
    sclk_low_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R8
    mosi_high_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> mosi);

    // R10
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    release_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done);

    // R5
    timeout_code_chk: assert property (@(posedge clk) disable iff (rst)
        done && timeout |-> resp == 8'hFF);

    // R1
    mosi_stable_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise_tick |=> $stable(mosi));

endmodule

// File: tb/sd_spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module sd_spi_cmd_engine_tb_top;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [7:0]       cmd = '0;
    logic [31:0]      arg = '0;
    logic [DIV_W-1:0] clk_div = '0;
    logic             late_sample = 1'b0;
    logic             miso = 1'b1;
    logic             sclk, cs_n, mosi, busy, done, timeout;
    logic [7:0]       resp;

    int      checks = 0;
    int      fails = 0;
    int      rise_cnt = 0;
    int      mosi_low_after = 0;
    int      cs_falls = 0;
    realtime t_prev = 0;
    realtime t_last = 0;
    logic [47:0] seen_frame;

    always #4 clk = ~clk;

    sd_spi_cmd_engine #(.DIV_W(DIV_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cmd         (cmd),
        .arg         (arg),
        .clk_div     (clk_div),
        .late_sample (late_sample),
        .miso        (miso),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .busy        (busy),
        .done        (done),
        .resp        (resp),
        .timeout     (timeout)
    );

    always @(posedge sclk) begin
        if (!cs_n) begin
            rise_cnt++;
            if (rise_cnt > 48 && !mosi) mosi_low_after++;
        end
        t_prev = t_last;
        t_last = $realtime;
    end

    always @(negedge cs_n) cs_falls++;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [39:0] p);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic f;
            f = c[6] ^ p[i];
            c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    // Card model: captures the frame, then answers after 'gap' idle bit times.
    task automatic card(input int gap, input logic [7:0] r, input bit respond, input bit slow);
        logic [47:0] f;
        f = '0;
        miso = 1'b1;
        for (int i = 0; i < 48; i++) begin
            @(posedge sclk);
            f = {f[46:0], mosi};
        end
        seen_frame = f;
        if (respond) begin
            for (int i = 0; i < gap; i++) @(negedge sclk);
            for (int i = 0; i < 8; i++) begin
                @(negedge sclk);
                if (slow) begin
                    miso = ~r[7-i];
                    #12;
                end
                miso = r[7-i];
            end
            @(negedge sclk);
            miso = 1'b1;
        end
    endtask

    task automatic run_cmd(input string req, input logic [7:0] c, input logic [31:0] a,
                           input int div, input bit late, input int gap,
                           input logic [7:0] r, input bit respond, input bit slow,
                           input bit poke);
        logic [47:0] exp_frame;
        int          exp_rises;
        int          waited;
        exp_frame = {c, a, ref_crc({c, a}), 1'b1};
        exp_rises = respond ? (48 + gap + 8 + 8) : (48 + 64 + 8);
        @(negedge clk);
        clk_div = DIV_W'(div);
        late_sample = late;
        rise_cnt = 0;
        mosi_low_after = 0;
        cs_falls = 0;
        fork
            card(gap, r, respond, slow);
            begin
                cmd = c;
                arg = a;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R9", "busy after start", busy, 1);
                if (poke) begin
                    repeat (30) @(negedge clk);
                    cmd = 8'h7A;
                    arg = 32'h0BAD_F00D;
                    clk_div = '0;
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
                waited = 0;
                while (!done && waited < 20000) begin
                    @(negedge clk);
                    waited++;
                end
                check("R10", "cs_n at done", cs_n, 1);
                check("R10", "busy at done", busy, 0);
                if (respond) begin
                    check("R4", "reply byte", resp, r);
                    check("R4", "timeout clear", timeout, 0);
                end else begin
                    check("R5", "timeout code", resp, 8'hFF);
                    check("R5", "timeout flag", timeout, 1);
                end
                @(negedge clk);
                check("R10", "done width", done, 0);
            end
        join
        check("R1", "frame bits", seen_frame, exp_frame);
        check("R8", "rising edges under select", rise_cnt, exp_rises);
        check("R4", "mosi low after frame", mosi_low_after, 0);
        check("R6", "sclk period ns", longint'(t_last - t_prev), longint'(2 * (div + 1) * 8));
        if (poke) begin
            repeat (40) @(negedge clk);
            check("R9", "transactions started", cs_falls, 1);
            check("R9", "idle after ignored start", cs_n, 1);
        end
        $display("%s scenario complete", req);
    endtask

    task automatic t_reset;
        check("R11", "cs_n", cs_n, 1);
        check("R11", "sclk", sclk, 0);
        check("R11", "mosi", mosi, 1);
        check("R11", "busy", busy, 0);
        check("R11", "done", done, 0);
        check("R11", "resp", resp, 8'hFF);
        check("R11", "timeout", timeout, 0);
    endtask

    task automatic t_go_idle;      // R2 R3 canonical reset command
        run_cmd("R2", 8'h40, 32'h0, 1, 1'b0, 1, 8'h01, 1'b1, 1'b0, 1'b0);
        check("R2", "crc byte of cmd 0x40", seen_frame[7:0], 8'h95);
        check("R3", "start and tx bits", seen_frame[47:46], 2'b01);
    endtask

    task automatic t_if_cond;      // R2 known checksum with an argument
        run_cmd("R2", 8'h48, 32'h0000_01AA, 0, 1'b0, 0, 8'h01, 1'b1, 1'b0, 1'b0);
        check("R2", "crc byte of cmd 0x48", seen_frame[7:0], 8'h87);
    endtask

    task automatic t_dense_arg;    // R1 R6 slower clock, dense payload
        run_cmd("R1", 8'h51, 32'hDEAD_BEEF, 3, 1'b0, 5, 8'h05, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_late_edge;    // R7 slow card read on falling edge
        run_cmd("R7", 8'h77, 32'h1234_5678, 0, 1'b1, 2, 8'h00, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_last_slot;    // R5 reply in the final bit time of the window
        run_cmd("R5", 8'h4D, 32'h0000_0001, 0, 1'b0, 63, 8'h04, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_no_reply;     // R5 silent card
        run_cmd("R5", 8'h41, 32'h4000_0000, 0, 1'b0, 0, 8'hFF, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_busy_guard;   // R9 second start mid-frame is ignored
        run_cmd("R9", 8'h50, 32'h0000_0200, 2, 1'b0, 3, 8'h00, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_recover;      // R10 flag clears on the next good reply
        run_cmd("R10", 8'h4D, 32'h0, 1, 1'b1, 4, 8'h00, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(1_000_000);
        fails++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_go_idle();
        t_if_cond();
        t_dense_arg();
        t_late_edge();
        t_last_slot();
        t_no_reply();
        t_recover();
        t_busy_guard();
        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule